// File: doc/BRIEF.md
# Per-Bit Interrupt Fan-Out Controller

This controller takes one group of 32 interrupt source lines and spreads the result over 10 output lines, one for each low status bit. When the event input is high, the block forms a selection: the active source lines that are also in the accumulated enable set. Each selected bit below 10 is handled on its own. If the bit is free, the block latches it into status and raises its output line. If the bit is masked, or its status is still set, the block records it as pending.

Software uses the same enable register for two jobs. A write that adds new bits grows the enable set. A write that adds no new bits masks or unmasks sources while a handler runs. Software acknowledges a source by writing ones to status bits. For each bit acknowledged, a pending event is replayed on that bit, or the output line for that bit drops. A write of all ones clears status without touching the outputs, which lets software initialise the register. A write of zero does nothing.

Top module: `intc_fanout`

## Requirements
- R1: After reset, every output line is low, both registers read zero, and the accumulated enable, mask and pending sets are empty, so an event selects nothing.
- R2: A selection forms only in a cycle where `evt_i` is high, and it is `src_i` ANDed with the accumulated enables. When `evt_i` is low the sources have no effect.
- R3: For each selected bit i below 10: if mask bit i or status bit i is set, pending bit i is set. Otherwise status bit i is set and `irq_o[i]` goes high. Both results are visible after the clock edge.
- R4: Selected bits at positions 10 and above change neither status nor pending, and they raise no output.
- R5: An enable write (`addr_i`=0) whose data holds a bit not yet in the accumulated enables ORs that data into the set, stores the data as the readback value and leaves the mask unchanged. A zero write while the set is empty only stores zero.
- R6: Any other enable write computes the difference between the stored readback and the data. If that difference shares a bit with the data, the differing bits are unmasked. Otherwise the differing bits are masked. The data is then stored.
- R7: A status write (`addr_i`=1) of zero changes nothing.
- R8: A nonzero status write that is not all ones clears the written status bits. Then, for each written bit i below 10: if pending bit i is set, status bit i is set again, pending bit i is cleared and `irq_o[i]` is high. Otherwise `irq_o[i]` goes low.
- R9: A status write of 0xFFFFFFFF clears all status bits and leaves the pending bits and the output lines unchanged.
- R10: Capture, replay and release on one bit never change the status, pending or output of any other bit.
- R11: If a register write and an event fall in the same cycle, the event sees the state left by that write.
- R12: `rdata_o` is combinational. With `addr_i`=0 it shows the last enable data stored. With `addr_i`=1 it shows status, zero-extended from bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Source line levels |
| evt_i | input | 1 | Group event; the sources are sampled when it is high |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = enable, 1 = status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Readback of the selected register |
| irq_o | output | 10 | One output line per low status bit |

## Verification
The pending and mask sets never appear in a register. A bad bit in either one shows up only later, on the output line of that bit. A pending bit that was lost or is left over shows as a missing or extra reassertion on the first acknowledge write to that bit. A wrong mask bit shows as status that fails to latch on the next event that selects that bit. The bench therefore follows every register write or event with a readback of both registers and a check of the output lines in the next cycle, so a fault surfaces within one acknowledge of the bit it affects.

// File: rtl/intc_fanout_pkg.sv
package intc_fanout_pkg;
  typedef enum logic {
    REG_ENABLE = 1'b0,
    REG_STATUS = 1'b1
  } fan_reg_e;
endpackage

// File: rtl/fan_en_ctl.sv
module fan_en_ctl #(
  parameter int SRC_W   = 32,
  parameter int NUM_OUT = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SRC_W-1:0]   wdata_i,
  output logic [SRC_W-1:0]   en_reg_o,
  output logic [SRC_W-1:0]   acc_nxt_o,
  output logic [NUM_OUT-1:0] mask_nxt_o
);
  logic [SRC_W-1:0] acc_q, reg_q, mask_q;
  logic [SRC_W-1:0] acc_n, reg_n, mask_n, chg;

  always_comb begin
    acc_n  = acc_q;
    reg_n  = reg_q;
    mask_n = mask_q;
    chg    = reg_q ^ wdata_i;
    if (we_i) begin
      reg_n = wdata_i;
      if (wdata_i == '0 && acc_q == '0) begin
        acc_n = acc_q;
      end else if ((acc_q | wdata_i) != acc_q) begin
        acc_n = acc_q | wdata_i;
      end else if ((chg & wdata_i) != '0) begin
        mask_n = mask_q & ~chg;
      end else begin
        mask_n = mask_q | chg;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      reg_q  <= '0;
      mask_q <= '0;
    end else begin
      acc_q  <= acc_n;
      reg_q  <= reg_n;
      mask_q <= mask_n;
    end
  end

  assign en_reg_o   = reg_q;
  assign acc_nxt_o  = acc_n;
  assign mask_nxt_o = mask_n[NUM_OUT-1:0];

  // accumulated enables never lose a bit
  assert_acc_monotonic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

  // mask moves only on a write that added no enable bit
  assert_mask_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_q) |-> ($past(we_i) && $stable(acc_q)));
endmodule

// File: rtl/fan_bit_cell.sv
module fan_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic mask_i,
  input  logic clr_i,
  input  logic clr_all_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q, pend_q, irq_q;
  logic stat_n, pend_n, irq_n;

  always_comb begin
    stat_n = stat_q;
    pend_n = pend_q;
    irq_n  = irq_q;
    // acknowledge first, then the event sees the result
    if (clr_i) begin
      stat_n = 1'b0;
      if (!clr_all_i) begin
        if (pend_q) begin
          stat_n = 1'b1;
          pend_n = 1'b0;
          irq_n  = 1'b1;
        end else begin
          irq_n = 1'b0;
        end
      end
    end
    if (sel_i) begin
      if (mask_i || stat_n) begin
        pend_n = 1'b1;
      end else begin
        stat_n = 1'b1;
        irq_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      pend_q <= pend_n;
      irq_q  <= irq_n;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  assert_pend_from_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(sel_i));

  assert_irq_drop_on_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(clr_i && !clr_all_i));

  assert_replay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !clr_all_i && pend_q && !sel_i) |=> (irq_q && stat_q && !pend_q));
endmodule

// File: rtl/intc_fanout.sv
module intc_fanout
  import intc_fanout_pkg::*;
#(
  parameter int SRC_W   = 32,
  parameter int NUM_OUT = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   src_i,
  input  logic               evt_i,
  input  logic               we_i,
  input  logic               addr_i,
  input  logic [SRC_W-1:0]   wdata_i,
  output logic [SRC_W-1:0]   rdata_o,
  output logic [NUM_OUT-1:0] irq_o
);
  logic [SRC_W-1:0]   en_reg, acc_nxt, sel_full, stat_ext;
  logic [NUM_OUT-1:0] mask_nxt, stat_vec;
  logic               en_we, st_we, st_all;
  logic               unused_sel_hi;

  assign en_we  = we_i && (addr_i == REG_ENABLE);
  assign st_we  = we_i && (addr_i == REG_STATUS) && (wdata_i != '0);
  assign st_all = (wdata_i == '1);

  fan_en_ctl #(.SRC_W(SRC_W), .NUM_OUT(NUM_OUT)) u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (en_we),
    .wdata_i    (wdata_i),
    .en_reg_o   (en_reg),
    .acc_nxt_o  (acc_nxt),
    .mask_nxt_o (mask_nxt)
  );

  assign sel_full      = evt_i ? (src_i & acc_nxt) : '0;
  // high selected bits have no line to drive
  assign unused_sel_hi = ^sel_full[SRC_W-1:NUM_OUT];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    fan_bit_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (sel_full[i]),
      .mask_i    (mask_nxt[i]),
      .clr_i     (st_we && wdata_i[i]),
      .clr_all_i (st_all),
      .stat_o    (stat_vec[i]),
      .irq_o     (irq_o[i])
    );
  end

  always_comb begin
    stat_ext              = '0;
    stat_ext[NUM_OUT-1:0] = stat_vec;
  end

  assign rdata_o = (addr_i == REG_STATUS) ? stat_ext : en_reg;

  assert_zero_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_STATUS && wdata_i == '0 && !evt_i)
      |=> ($stable(irq_o) && $stable(stat_vec)));

  assert_clear_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_STATUS && wdata_i == '1 && !evt_i)
      |=> (stat_vec == '0 && $stable(irq_o)));
endmodule

// File: tb/sim_intc_fanout.sv
`timescale 1ns/1ps
module sim_intc_fanout;
  localparam int SW = 32;
  localparam int NO = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [SW-1:0] src_i = '0;
  logic          evt_i = 1'b0;
  logic          we_i = 1'b0;
  logic          addr_i = 1'b0;
  logic [SW-1:0] wdata_i = '0;
  logic [SW-1:0] rdata_o;
  logic [NO-1:0] irq_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [SW-1:0] m_acc = '0, m_reg = '0, m_mask = '0;
  logic [NO-1:0] m_stat = '0, m_pend = '0, m_irq = '0;

  always #2 clk = ~clk;

  intc_fanout u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .evt_i(evt_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic we, input logic ad, input logic [SW-1:0] d,
                       input logic ev, input logic [SW-1:0] s);
    logic [SW-1:0] ch, sel;
    if (we && !ad) begin
      if (d == '0 && m_acc == '0) m_reg = d;
      else if ((m_acc | d) != m_acc) begin m_acc = m_acc | d; m_reg = d; end
      else begin
        ch = m_reg ^ d;
        if ((ch & d) != '0) m_mask = m_mask & ~ch; else m_mask = m_mask | ch;
        m_reg = d;
      end
    end
    if (we && ad && d != '0) begin
      m_stat = m_stat & ~d[NO-1:0];
      if (d != '1) begin
        for (int i = 0; i < NO; i++) if (d[i]) begin
          if (m_pend[i]) begin m_stat[i] = 1'b1; m_pend[i] = 1'b0; m_irq[i] = 1'b1; end
          else m_irq[i] = 1'b0;
        end
      end
    end
    if (ev) begin
      sel = s & m_acc;
      for (int i = 0; i < NO; i++) if (sel[i]) begin
        if (m_mask[i] || m_stat[i]) m_pend[i] = 1'b1;
        else begin m_stat[i] = 1'b1; m_irq[i] = 1'b1; end
      end
    end
  endtask

  task automatic check_all(input string tag);
    addr_i = 1'b0; #0.4;
    chk(tag, "enable_rd", rdata_o, m_reg);
    addr_i = 1'b1; #0.4;
    chk(tag, "status_rd", rdata_o, {{(SW-NO){1'b0}}, m_stat});
    chk(tag, "irq", {{(SW-NO){1'b0}}, irq_o}, {{(SW-NO){1'b0}}, m_irq});
  endtask

  // called just after a negedge
  task automatic step(input logic we, input logic ad, input logic [SW-1:0] d,
                      input logic ev, input logic [SW-1:0] s, input string tag);
    we_i = we; addr_i = ad; wdata_i = d; evt_i = ev; src_i = s;
    @(posedge clk); #1;
    we_i = 1'b0; evt_i = 1'b0;
    model(we, ad, d, ev, s);
    check_all(tag);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    logic [SW-1:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #0.2;
    check_all("R1");
    @(negedge clk);
    step(0, 0, '0, 1, '1, "R1");                    // no enables yet
    step(1, 0, 32'hA5A5_A5A5, 0, '0, "R12");
    step(1, 0, 32'h0000_03FF, 0, '0, "R5");
    step(0, 0, '0, 0, '1, "R2");                    // event low
    step(0, 0, '0, 1, 32'h0000_0005, "R3");
    step(0, 0, '0, 1, 32'h0000_0004, "R3");         // status set -> pending
    step(1, 0, 32'hFFFF_FFFF, 0, '0, "R5");
    step(0, 0, '0, 1, 32'hFFFF_FC00, "R4");
    step(1, 1, 32'h0000_0000, 0, '0, "R7");
    step(1, 1, 32'hFFFF_FFFF, 0, '0, "R9");         // outputs kept
    step(0, 0, '0, 1, 32'h0000_0001, "R9");
    step(1, 1, 32'h0000_0001, 0, '0, "R8");
    step(1, 1, 32'h0000_0004, 0, '0, "R8");         // pending replay
    step(1, 1, 32'h0000_0004, 0, '0, "R8");
    for (int i = 0; i < NO; i++) begin
      step(0, 0, '0, 1, SW'(1) << i, "R10");
      step(0, 0, '0, 1, SW'(1) << i, "R10");
      step(1, 1, SW'(1) << i, 0, '0, "R10");
      step(1, 1, SW'(1) << i, 0, '0, "R10");
    end
    step(1, 0, 32'hFFFF_FFFE, 0, '0, "R6");         // mask bit 0
    step(0, 0, '0, 1, 32'h0000_0001, "R6");
    step(1, 0, 32'hFFFF_FFFF, 0, '0, "R6");         // unmask bit 0
    step(1, 1, 32'h0000_0001, 0, '0, "R6");
    step(1, 1, 32'h0000_0001, 1, 32'h0000_0001, "R11");
    step(1, 0, 32'h0000_0000, 0, '0, "R6");         // masks all
    step(0, 0, '0, 1, 32'h0000_0003, "R6");
    r = 32'h1234_5678;
    for (int k = 0; k < 4000; k++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      r2 = r ^ 32'h9E37_79B9;
      case (r[1:0])
        2'd0: step(0, 0, '0, 1, r2 & 32'h0000_0FFF, "R3");
        2'd1: begin
          case (r[4:2])
            3'd0: d = '0;
            3'd1: d = '1;
            3'd2: d = r2;
            3'd3: d = r2 & 32'h0000_03FF;
            default: d = m_reg ^ (SW'(1) << r[9:5]);
          endcase
          step(1, 0, d, 0, '0, "R6");
        end
        2'd2: begin
          case (r[4:2])
            3'd0: d = '0;
            3'd1: d = '1;
            3'd2: d = SW'(1) << (r[8:5] % NO);
            default: d = r2 & 32'h0000_03FF;
          endcase
          step(1, 1, d, 0, '0, "R8");
        end
        default: step(1, r[2], r[3] ? (SW'(1) << (r[8:5] % NO)) : r2,
                      1, r2 & 32'h0000_07FF, "R11");
      endcase
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule